// File: doc/BRIEF.md
# Tile Row Single-Precision to 16-Bit Packer

This block takes one row of a matrix tile, picks one vector-sized window of that row, and rounds every 32-bit single-precision word in the window to a 16-bit float. Each result goes into its own 32-bit output lane. A mode input picks the 16-bit format: brain-float16 (8-bit exponent, 7-bit fraction) or IEEE binary16 (5-bit exponent, 10-bit fraction). A placement input puts the 16-bit result in the upper or the lower half of the lane. The other half of the lane is always zero. Lanes whose source word lies past the configured row width come out as all zeros.

A 32-bit selector names the row and the window. The row number is driven out combinationally to the tile storage, which sits outside this block. The storage returns that row in the same cycle. The selected window index, multiplied by the vector width, gives the byte offset of the window within the row. All inputs are captured on the valid strobe, and the 512-bit result is registered one cycle later.

Top module: `tile_row_packer`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0 and `out_vec` is all zeros until the first accepted request.
- R2: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` high. While `in_valid` is low, `out_vec` keeps its last value.
- R3: `rd_row` equals `sel[15:0]`. Lane i (bits 32i+31:32i) is produced from row word `sel[31:16]*16 + i`, where row word k is `row_data[32k+31:32k]`.
- R4: A lane whose source word index is at or beyond `floor(row_bytes/4)` is all zeros, in any mode and placement. A lane whose source word index is beyond the row storage is also all zeros.
- R5: With `place_hi`=1, an active lane carries its 16-bit result in bits 31:16, and bits 15:0 are zero.
- R6: With `place_hi`=0, an active lane carries its 16-bit result in bits 15:0, and bits 31:16 are zero.
- R7: With `fmt_sel`=0 (brain-float16), the result is the top 16 bits of the input, rounded to nearest-even on the 16 dropped bits. A finite value that rounds past the largest value becomes infinity.
- R8: With `fmt_sel`=0, a NaN input gives sign, exponent 0xFF, fraction bit 6 set, and fraction bits 5:0 taken from input fraction bits 21:16.
- R9: With `fmt_sel`=1 (binary16), normal results are rounded to nearest-even. A finite value at or above 2^16, or one that rounds up past 65504, becomes signed infinity (0x7C00 | sign).
- R10: With `fmt_sel`=1, values below 2^-14 are rounded to nearest-even into binary16 subnormals in units of 2^-24. A value that rounds up becomes 0x0400. Values of 2^-25 or less become signed zero.
- R11: With `fmt_sel`=1, an infinite input gives signed infinity. A NaN input gives sign, exponent 0x1F, fraction bit 9 set, and fraction bits 8:0 taken from input fraction bits 21:13.
- R12: Changes of `fmt_sel`, `place_hi`, `sel`, `row_bytes` or `row_data` while `in_valid` is low do not change `out_vec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe; all other inputs are sampled with it |
| fmt_sel | input | 1 | 0 = brain-float16, 1 = binary16 |
| place_hi | input | 1 | 1 = result in upper half of each lane, 0 = lower half |
| sel | input | 32 | [15:0] row number, [31:16] window index |
| row_bytes | input | 8 | Configured row width in bytes |
| rd_row | output | 16 | Row number presented to tile storage |
| row_data | input | 1024 | Contents of the addressed row, word k at bits 32k+31:32k |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_vec | output | 512 | Sixteen packed 32-bit lanes |

## Verification
The bench goes after exact rounding ties in both formats. A converter that rounds half-up would give 0x3F81 instead of 0x3F80 for brain-float16, and 0x3C01 instead of 0x3C00 for binary16. It also covers the binary16 overflow edge, where 65520 must become infinity while 65504 stays finite. At the subnormal boundary, 2^-25 must round to zero, 1.5·2^-25 to the smallest subnormal, and 2^-14 to the smallest normal; a wrong shift count would misplace these by a factor of two. NaN payload forwarding and window masking are also checked, including a row width that is not a multiple of four and a window that starts past the row end. A wrong limit would leak stale words into lanes that must be zero.

// File: rtl/tile_row_packer_pkg.sv
package tile_row_packer_pkg;

   localparam int LANE_W = 32;
   localparam int HALF_W = 16;

   typedef enum logic {
      FMT_BF16 = 1'b0,
      FMT_FP16 = 1'b1
   } fmt_e;

endpackage

// File: rtl/trp_cvt_bf16.sv
// Single-precision to brain-float16, round to nearest-even, quiet NaN out.
module trp_cvt_bf16 (
   input  logic [31:0] din,
   output logic [15:0] dout
);
   logic        is_nan;
   logic        rnd_up;
   logic [15:0] upper;

   always_comb begin
      is_nan = (din[30:23] == 8'hFF) && (din[22:0] != 23'd0);
      upper  = din[31:16];
      rnd_up = din[15] & ((|din[14:0]) | din[16]);
      if (is_nan)
         dout = {din[31], 8'hFF, 1'b1, din[21:16]};
      else
         dout = upper + {15'd0, rnd_up};
   end
endmodule

// File: rtl/trp_cvt_fp16.sv
// Single-precision to binary16, round to nearest-even with subnormal output.
module trp_cvt_fp16 (
   input  logic [31:0] din,
   output logic [15:0] dout
);
   logic        sgn;
   logic [7:0]  exp8;
   logic [22:0] frac;
   logic [14:0] nrm_base;
   logic        nrm_rnd;
   logic [7:0]  sh_raw;
   logic [4:0]  sh;
   logic [47:0] ext;
   logic [23:0] sig;
   logic        sub_rnd;
   logic [14:0] mag;

   always_comb begin
      sgn  = din[31];
      exp8 = din[30:23];
      frac = din[22:0];

      // normal path: rebias 127 -> 15
      nrm_base = {exp8[4:0] - 5'd16, frac[22:13]};
      nrm_rnd  = frac[12] & ((|frac[11:0]) | frac[13]);

      // subnormal path: value in units of 2^-24 is sig >> (126 - exp)
      sig    = {(exp8 != 8'd0), frac};
      sh_raw = 8'd126 - exp8;
      sh     = (sh_raw > 8'd31) ? 5'd31 : sh_raw[4:0];
      ext    = {sig, 24'd0} >> sh;
      sub_rnd = ext[23] & ((|ext[22:0]) | ext[24]);

      if (exp8 == 8'hFF)
         mag = (frac != 23'd0) ? {5'h1F, 1'b1, frac[21:13]} : 15'h7C00;
      else if (exp8 >= 8'd143)
         mag = 15'h7C00;
      else if (exp8 >= 8'd113)
         mag = nrm_base + {14'd0, nrm_rnd};
      else
         mag = ext[38:24] + {14'd0, sub_rnd};

      dout = {sgn, mag};
   end
endmodule

// File: rtl/trp_lane.sv
// One output lane: source word pick, width mask, both converters, placement.
module trp_lane
   import tile_row_packer_pkg::*;
#(
   parameter int LANE_IX   = 0,
   parameter int LANES     = 16,
   parameter int ROW_WORDS = 32,
   parameter int CB_W      = 8
) (
   input  logic [ROW_WORDS*LANE_W-1:0] row_data,
   input  logic [15:0]                 chunk,
   input  logic [CB_W-1:0]             row_bytes,
   input  logic                        fmt_sel,
   input  logic                        place_hi,
   output logic [LANE_W-1:0]           lane
);
   localparam int IW = $clog2(ROW_WORDS);

   logic [31:0]       idx;
   logic [31:0]       lim;
   logic              live;
   logic [IW-1:0]     widx;
   logic [LANE_W-1:0] src;
   logic [HALF_W-1:0] h_bf;
   logic [HALF_W-1:0] h_fp;
   logic [HALF_W-1:0] half;
   fmt_e              fmt;

   always_comb begin
      idx  = 32'(chunk) * 32'(LANES) + 32'(LANE_IX);
      lim  = 32'(row_bytes >> 2);
      live = (idx < lim) && (idx < 32'(ROW_WORDS));
      widx = idx[IW-1:0];
      src  = row_data[LANE_W*widx +: LANE_W];
   end

   trp_cvt_bf16 u_bf (.din(src), .dout(h_bf));
   trp_cvt_fp16 u_fp (.din(src), .dout(h_fp));

   always_comb begin
      fmt  = fmt_e'(fmt_sel);
      half = (fmt == FMT_FP16) ? h_fp : h_bf;
      if (!live)
         lane = '0;
      else if (place_hi)
         lane = {half, {HALF_W{1'b0}}};
      else
         lane = {{HALF_W{1'b0}}, half};
   end
endmodule

// File: rtl/tile_row_packer.sv
module tile_row_packer
   import tile_row_packer_pkg::*;
#(
   parameter int VEC_BITS  = 512,
   parameter int ROW_BYTES = 128,
   parameter int CB_W      = $clog2(ROW_BYTES) + 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic                      fmt_sel,
   input  logic                      place_hi,
   input  logic [31:0]               sel,
   input  logic [CB_W-1:0]           row_bytes,
   output logic [15:0]               rd_row,
   input  logic [ROW_BYTES*8-1:0]    row_data,
   output logic                      out_valid,
   output logic [VEC_BITS-1:0]       out_vec
);
   localparam int LANES     = VEC_BITS / LANE_W;
   localparam int ROW_WORDS = ROW_BYTES / 4;

   if (VEC_BITS % LANE_W != 0) begin : g_bad_vec
      $error("VEC_BITS must be a multiple of 32");
   end
   if (ROW_BYTES % 4 != 0 || ROW_BYTES < 8) begin : g_bad_row
      $error("ROW_BYTES must be a multiple of 4 and at least 8");
   end
   if ((1 << (CB_W - 1)) < ROW_BYTES) begin : g_bad_cbw
      $error("CB_W too narrow for ROW_BYTES");
   end

   logic [15:0]         chunk;
   logic [VEC_BITS-1:0] nxt_vec;

   assign rd_row = sel[15:0];
   assign chunk  = sel[31:16];

   for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
      trp_lane #(
         .LANE_IX  (gi),
         .LANES    (LANES),
         .ROW_WORDS(ROW_WORDS),
         .CB_W     (CB_W)
      ) u_lane (
         .row_data (row_data),
         .chunk    (chunk),
         .row_bytes(row_bytes),
         .fmt_sel  (fmt_sel),
         .place_hi (place_hi),
         .lane     (nxt_vec[gi*LANE_W +: LANE_W])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_vec   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            out_vec <= nxt_vec;
      end
   end
endmodule

// File: rtl/tile_row_packer_chk.sv
module tile_row_packer_chk #(
   parameter int VEC_BITS = 512,
   parameter int CB_W     = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                place_hi,
   input logic [CB_W-1:0]     row_bytes,
   input logic                out_valid,
   input logic [VEC_BITS-1:0] out_vec
);
   function automatic logic [VEC_BITS-1:0] low_halves();
      logic [VEC_BITS-1:0] m;
      m = '0;
      for (int k = 0; k < VEC_BITS / 32; k++)
         m[k*32 +: 16] = 16'hFFFF;
      return m;
   endfunction

   localparam logic [VEC_BITS-1:0] LO_MASK = low_halves();
   localparam logic [VEC_BITS-1:0] HI_MASK = ~LO_MASK;

   p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_hold_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_vec));

   p_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && place_hi) |=> ((out_vec & LO_MASK) == '0));

   p_high_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !place_hi) |=> ((out_vec & HI_MASK) == '0));

   p_empty_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && row_bytes < CB_W'(4)) |=> (out_vec == '0));
endmodule

bind tile_row_packer tile_row_packer_chk #(
   .VEC_BITS(VEC_BITS),
   .CB_W    (CB_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .place_hi (place_hi),
   .row_bytes(row_bytes),
   .out_valid(out_valid),
   .out_vec  (out_vec)
);

// File: tb/tile_row_packer_tb_top.sv
module tile_row_packer_tb_top;
   logic          clk = 1'b0;
   logic          rst_n;
   logic          in_valid;
   logic          fmt_sel;
   logic          place_hi;
   logic [31:0]   sel;
   logic [7:0]    row_bytes;
   logic [15:0]   rd_row;
   logic [1023:0] row_data;
   logic          out_valid;
   logic [511:0]  out_vec;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] rw [32];

   always #5 clk = ~clk;

   tile_row_packer dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_sel(fmt_sel),
      .place_hi(place_hi), .sel(sel), .row_bytes(row_bytes), .rd_row(rd_row),
      .row_data(row_data), .out_valid(out_valid), .out_vec(out_vec)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   function automatic logic [31:0] lane_of(input int i);
      return out_vec[i*32 +: 32];
   endfunction

   task automatic load_row();
      for (int k = 0; k < 32; k++) row_data[k*32 +: 32] = rw[k];
   endtask

   // drive one request; returns after the result register has updated
   task automatic issue(input logic f, input logic hi, input logic [31:0] s, input logic [7:0] rb);
      @(negedge clk);
      load_row();
      fmt_sel = f; place_hi = hi; sel = s; row_bytes = rb; in_valid = 1'b1;
      chk("R3 rd_row", {16'd0, rd_row}, {16'd0, s[15:0]});
      @(negedge clk);
      in_valid = 1'b0;
      chk("R2 out_valid after request", {31'd0, out_valid}, 32'd1);
   endtask

   task automatic t_reset();
      chk("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
      chk("R1 out_vec lane0 in reset", lane_of(0), 32'd0);
      chk("R1 out_vec lane15 in reset", lane_of(15), 32'd0);
   endtask

   task automatic t_bf16_hi();
      logic [15:0] ex [8];
      for (int k = 0; k < 32; k++) rw[k] = 32'h0;
      rw[0] = 32'h3F800000; ex[0] = 16'h3F80;
      rw[1] = 32'h3F808000; ex[1] = 16'h3F80; // tie, even stays
      rw[2] = 32'h3F818000; ex[2] = 16'h3F82; // tie, odd rounds up
      rw[3] = 32'h3F808001; ex[3] = 16'h3F81;
      rw[4] = 32'h7F7FFFFF; ex[4] = 16'h7F80; // overflow to inf
      rw[5] = 32'h7FC00001; ex[5] = 16'h7FC0; // NaN
      rw[6] = 32'hFF812345; ex[6] = 16'hFFC1; // signalling NaN, sign kept
      rw[7] = 32'hC0490FDB; ex[7] = 16'hC049;
      issue(1'b0, 1'b1, 32'h0000_0003, 8'd128);
      for (int i = 0; i < 8; i++)
         chk((i == 5 || i == 6) ? "R8 bf16 NaN" : "R7/R5 bf16 high", lane_of(i), {ex[i], 16'h0});
   endtask

   task automatic t_fp16_lo();
      logic [15:0] ex [16];
      rw[0]  = 32'h3F800000; ex[0]  = 16'h3C00;
      rw[1]  = 32'h477FE000; ex[1]  = 16'h7BFF; // 65504
      rw[2]  = 32'h477FF000; ex[2]  = 16'h7C00; // 65520 -> inf
      rw[3]  = 32'hC0000000; ex[3]  = 16'hC000;
      rw[4]  = 32'h3F801000; ex[4]  = 16'h3C00; // tie even
      rw[5]  = 32'h3F803000; ex[5]  = 16'h3C02; // tie odd
      rw[6]  = 32'h33800000; ex[6]  = 16'h0001; // 2^-24
      rw[7]  = 32'h33000000; ex[7]  = 16'h0000; // 2^-25 tie -> 0
      rw[8]  = 32'h33400000; ex[8]  = 16'h0001; // 1.5*2^-25
      rw[9]  = 32'h38800000; ex[9]  = 16'h0400; // 2^-14
      rw[10] = 32'hAEDBE6FF; ex[10] = 16'h8000; // tiny negative
      rw[11] = 32'h00000001; ex[11] = 16'h0000;
      rw[12] = 32'h7F800000; ex[12] = 16'h7C00;
      rw[13] = 32'hFF800000; ex[13] = 16'hFC00;
      rw[14] = 32'h7FC00000; ex[14] = 16'h7E00;
      rw[15] = 32'h7F800001; ex[15] = 16'h7E00; // signalling NaN quieted
      issue(1'b1, 1'b0, 32'h0000_0000, 8'd128);
      for (int i = 0; i < 16; i++) begin
         if (i < 6)       chk("R9/R6 fp16 normal", lane_of(i), {16'h0, ex[i]});
         else if (i < 12) chk("R10 fp16 subnormal", lane_of(i), {16'h0, ex[i]});
         else             chk("R11 fp16 inf/NaN", lane_of(i), {16'h0, ex[i]});
      end
   endtask

   task automatic t_chunk();
      for (int k = 0; k < 32; k++) rw[k] = 32'h4000_0000 + (32'(k) << 16);
      issue(1'b0, 1'b0, {16'd1, 16'd5}, 8'd128);
      for (int i = 0; i < 16; i++)
         chk("R3 window 1 word pick", lane_of(i), {16'h0, 16'h4010 + 16'(i)});
   endtask

   task automatic t_mask();
      issue(1'b0, 1'b1, 32'h0000_0000, 8'd22); // 5 live words
      for (int i = 0; i < 16; i++)
         chk("R4 mask partial width", lane_of(i), (i < 5) ? {16'h4000 + 16'(i), 16'h0} : 32'h0);
      issue(1'b1, 1'b1, {16'd1, 16'd0}, 8'd64); // window starts past end
      for (int i = 0; i < 16; i++)
         chk("R4 mask whole window", lane_of(i), 32'h0);
      issue(1'b0, 1'b0, {16'd1, 16'd0}, 8'd70); // 17 live words
      chk("R4 mask lane0 live", lane_of(0), {16'h0, 16'h4010});
      chk("R4 mask lane1 dead", lane_of(1), 32'h0);
      issue(1'b0, 1'b0, {16'd2, 16'd0}, 8'd128); // beyond storage
      chk("R4 beyond storage", lane_of(0), 32'h0);
   endtask

   task automatic t_hold();
      logic [31:0] l0, l7;
      issue(1'b0, 1'b1, 32'h0000_0000, 8'd128);
      l0 = lane_of(0); l7 = lane_of(7);
      chk("R5 lane0 high", l0, {16'h4000, 16'h0});
      @(negedge clk);
      chk("R2 out_valid drops", {31'd0, out_valid}, 32'd0);
      fmt_sel = 1'b1; place_hi = 1'b0; sel = {16'd1, 16'd9}; row_bytes = 8'd4;
      for (int k = 0; k < 32; k++) rw[k] = 32'h3F800000;
      load_row();
      repeat (3) @(negedge clk);
      chk("R12 lane0 held while idle", lane_of(0), l0);
      chk("R12 lane7 held while idle", lane_of(7), l7);
   endtask

   initial begin
      in_valid = 1'b0; fmt_sel = 1'b0; place_hi = 1'b0; sel = '0;
      row_bytes = '0; row_data = '0; rst_n = 1'b0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bf16_hi();
      t_fp16_lo();
      t_chunk();
      t_mask();
      t_hold();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule